// File: doc/BRIEF.md
# Serial Command and Register Port

This block is the slave side of a byte-oriented serial control port for a radio signalling codec. A host drives a serial clock, a data line and an active-low chip select. Each transfer starts with one command byte, and the value of that byte sets what follows. It can be one or two data bytes that load an internal register, a one-byte status reply, or nothing at all in the case of the global reset command. The registers drive the codec's tone, code and audio functions, which are outside this block.

The serial pins are sampled by the system clock through a synchroniser, so the host clock must be several times slower than `clk`. There is no valid/ready handshake at the edge: the serial framing is the only flow control, and the host sets the pace. Event pulses from the codec set sticky interrupt flags. A mask register gates those flags onto an open-drain interrupt request. The reply line and the interrupt line are given as drive enables, so the pad ring builds the three-state and open-drain drivers.

Top module: `sigctl_serial_port`

## Requirements
- R1: After `rst_n` is low, every register output and `irq_flags` read zero, and `reply_oe` and `irq_pull` are low.
- R2: Bytes are shifted in most significant bit first, sampled on the rising serial clock. The commands 0x80 (`sig_ctrl`), 0x82 (`sig_setup`), 0x85 (`dcs_code[23:16]`), 0x86 (`dcs_code[15:8]`), 0x87 (`dcs_code[7:0]`), 0x88 (`gen_ctrl`), 0x8B (`gp_timer`) and 0x8E (`irq_mask`) each take one data byte into the named register.
- R3: The commands 0x83 (`subtone_word`), 0x84 (`rx_tone_word`), 0x8A (`audio_word`) and 0x8D (`selcall_word`) take two data bytes. The first byte lands in bits 15:8 and the second in bits 7:0.
- R4: Command 0x01 carries no data. It clears every register and every interrupt flag.
- R5: Raising `csn` before a transfer is complete discards it. This covers a partial byte and a two-byte write that has received only its first data byte. No register changes, and the next transfer starts cleanly.
- R6: A command byte of any other value, together with any bytes that follow it, changes no register.
- R7: Command 0x8F returns the flag byte, most significant bit first. `reply_oe` is high only while that byte is out, and `reply_data` changes only after a falling serial clock.
- R8: Reading the flags clears the bits that were returned. Events that arrive after the read set their bits again.
- R9: A high bit of `flag_set` in any clock sets the matching `irq_flags` bit. The bit holds until a read or a reset.
- R10: `irq_pull` is high exactly when some flag bit is set whose `irq_mask` bit is one.
- R11: Bytes that follow a completed payload inside the same `csn`-low window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle low |
| sdi | input | 1 | Serial command/data from host |
| csn | input | 1 | Active-low transfer select |
| flag_set | input | 8 | Event pulses that set interrupt flags |
| reply_data | output | 1 | Serial reply bit |
| reply_oe | output | 1 | Drive enable for the reply pad (low = high impedance) |
| irq_pull | output | 1 | High = pull the interrupt line low |
| sig_ctrl | output | 8 | Signalling control register |
| sig_setup | output | 8 | Signalling setup register |
| dcs_code | output | 24 | Digital code word |
| gen_ctrl | output | 8 | General control register |
| gp_timer | output | 8 | Timer reload value |
| irq_mask | output | 8 | Interrupt enable mask |
| subtone_word | output | 16 | Sub-audio tone word |
| rx_tone_word | output | 16 | Receive tone program word |
| audio_word | output | 16 | Audio gain word |
| selcall_word | output | 16 | In-band tone word |
| irq_flags | output | 8 | Sticky interrupt flags |

## Verification
The bench aborts a transfer twice: once in the middle of the command byte and once between the two data bytes of a 16-bit write. A design that keeps its bit count or its pending high byte would either corrupt the register or misframe every later command. Trailing bytes after a one-byte write, and unknown commands followed by data, are sent to catch a decoder that goes back to command decoding or writes through a wrong address. Flag reads are checked through a scoreboard of expected reply bytes. A design that shifts before the host samples would lose the top bit, and one that does not clear on read would return stale bits on the following read. Mask changes show whether the interrupt request follows the flag and mask combination.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] CMD_RESET    = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_SIGCTRL  = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_SETUP    = 8'h82;
  localparam logic [BYTE_W-1:0] CMD_SUBTONE  = 8'h83;
  localparam logic [BYTE_W-1:0] CMD_RXTONE   = 8'h84;
  localparam logic [BYTE_W-1:0] CMD_DCS_HI   = 8'h85;
  localparam logic [BYTE_W-1:0] CMD_DCS_MID  = 8'h86;
  localparam logic [BYTE_W-1:0] CMD_DCS_LO   = 8'h87;
  localparam logic [BYTE_W-1:0] CMD_GENCTRL  = 8'h88;
  localparam logic [BYTE_W-1:0] CMD_AUDIO    = 8'h8A;
  localparam logic [BYTE_W-1:0] CMD_TIMER    = 8'h8B;
  localparam logic [BYTE_W-1:0] CMD_SELCALL  = 8'h8D;
  localparam logic [BYTE_W-1:0] CMD_MASK     = 8'h8E;
  localparam logic [BYTE_W-1:0] CMD_FLAGS    = 8'h8F;

  typedef enum logic [2:0] {
    K_NONE, K_RESET, K_READ, K_ONE, K_TWO
  } cmd_kind_e;

  function automatic cmd_kind_e cmd_kind(input logic [BYTE_W-1:0] c);
    case (c)
      CMD_RESET: return K_RESET;
      CMD_FLAGS: return K_READ;
      CMD_SIGCTRL, CMD_SETUP, CMD_DCS_HI, CMD_DCS_MID, CMD_DCS_LO,
      CMD_GENCTRL, CMD_TIMER, CMD_MASK: return K_ONE;
      CMD_SUBTONE, CMD_RXTONE, CMD_AUDIO, CMD_SELCALL: return K_TWO;
      default: return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sp_shifter.sv
module sp_shifter
  import sp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              csn,
  input  logic              rd_load,
  input  logic [BYTE_W-1:0] rd_value,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val,
  output logic              xfer_idle,
  output logic              reply_data,
  output logic              reply_oe
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclk_q, sdi_q, csn_q;
  logic sclk_d, sclk_s, sdi_s, csn_s, rise, fall;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sreg, rsh;
  logic ract, sampled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdi_q  <= '0;
      csn_q  <= '1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      sdi_q  <= {sdi_q[SYNC_STAGES-2:0], sdi};
      csn_q  <= {csn_q[SYNC_STAGES-2:0], csn};
    end
  end

  assign sclk_s    = sclk_q[SYNC_STAGES-1];
  assign sdi_s     = sdi_q[SYNC_STAGES-1];
  assign csn_s     = csn_q[SYNC_STAGES-1];
  assign rise      = sclk_s & ~sclk_d;
  assign fall      = ~sclk_s & sclk_d;
  assign xfer_idle = csn_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cnt      <= '0;
      sreg     <= '0;
      rsh      <= '0;
      ract     <= 1'b0;
      sampled  <= 1'b0;
      byte_vld <= 1'b0;
      byte_val <= '0;
    end else begin
      sclk_d   <= sclk_s;
      byte_vld <= 1'b0;
      if (csn_s) begin
        cnt     <= '0;
        ract    <= 1'b0;
        sampled <= 1'b0;
      end else begin
        if (rise) begin
          sreg <= {sreg[BYTE_W-2:0], sdi_s};
          cnt  <= cnt + 1'b1;
          if (ract) sampled <= 1'b1;
          if (cnt == CNT_LAST) begin
            byte_vld <= 1'b1;
            byte_val <= {sreg[BYTE_W-2:0], sdi_s};
            cnt      <= '0;
            ract     <= 1'b0;
          end
        end else if (fall && sampled) begin
          rsh     <= {rsh[BYTE_W-2:0], 1'b0};
          sampled <= 1'b0;
        end
        if (rd_load) begin
          rsh     <= rd_value;
          ract    <= 1'b1;
          sampled <= 1'b0;
        end
      end
    end
  end

  assign reply_oe   = ract;
  assign reply_data = ract & rsh[BYTE_W-1];

  // R7: deselect releases the reply pad
  a_r7_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !reply_oe);
  // R7: reply bit moves only after a falling serial edge
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_oe && $past(reply_oe) && !$past(fall) && !$past(rd_load)) |-> $stable(reply_data));
endmodule

// File: rtl/sp_cmd_fsm.sv
module sp_cmd_fsm
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              xfer_idle,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_cmd,
  output logic [WORD_W-1:0] wr_data,
  output logic              soft_rst,
  output logic              rd_load
);
  typedef enum logic [1:0] {ST_CMD, ST_BYTE1, ST_BYTE2, ST_SKIP} st_e;
  st_e state;
  logic [BYTE_W-1:0] hi_q;
  logic two_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_CMD;
      wr_cmd   <= '0;
      hi_q     <= '0;
      two_q    <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      soft_rst <= 1'b0;
      rd_load  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      soft_rst <= 1'b0;
      rd_load  <= 1'b0;
      if (xfer_idle) begin
        state <= ST_CMD;
      end else if (byte_vld) begin
        case (state)
          ST_CMD: begin
            wr_cmd <= byte_val;
            state  <= ST_SKIP;
            case (cmd_kind(byte_val))
              K_RESET: soft_rst <= 1'b1;
              K_READ:  rd_load  <= 1'b1;
              K_ONE: begin two_q <= 1'b0; state <= ST_BYTE1; end
              K_TWO: begin two_q <= 1'b1; state <= ST_BYTE1; end
              default: ;
            endcase
          end
          ST_BYTE1: begin
            if (two_q) begin
              hi_q  <= byte_val;
              state <= ST_BYTE2;
            end else begin
              wr_en   <= 1'b1;
              wr_data <= {{BYTE_W{1'b0}}, byte_val};
              state   <= ST_SKIP;
            end
          end
          ST_BYTE2: begin
            wr_en   <= 1'b1;
            wr_data <= {hi_q, byte_val};
            state   <= ST_SKIP;
          end
          default: state <= ST_SKIP;
        endcase
      end
    end
  end

  // R4: the reset command never doubles as a write or a read
  a_r4_reset_alone: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!wr_en && !rd_load));
  // R5: deselect returns to command decoding with no write
  a_r5_abort_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_idle |=> (state == ST_CMD && !wr_en));
  // R11: at most one write per payload
  a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/sp_regbank.sv
module sp_regbank
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_cmd,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              soft_rst,
  input  logic              rd_load,
  input  logic [BYTE_W-1:0] flag_set,
  output logic [BYTE_W-1:0] sig_ctrl,
  output logic [BYTE_W-1:0] sig_setup,
  output logic [3*BYTE_W-1:0] dcs_code,
  output logic [BYTE_W-1:0] gen_ctrl,
  output logic [BYTE_W-1:0] gp_timer,
  output logic [BYTE_W-1:0] irq_mask,
  output logic [WORD_W-1:0] subtone_word,
  output logic [WORD_W-1:0] rx_tone_word,
  output logic [WORD_W-1:0] audio_word,
  output logic [WORD_W-1:0] selcall_word,
  output logic [BYTE_W-1:0] irq_flags,
  output logic              irq_pull
);
  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      sig_ctrl     <= '0;
      sig_setup    <= '0;
      dcs_code     <= '0;
      gen_ctrl     <= '0;
      gp_timer     <= '0;
      irq_mask     <= '0;
      subtone_word <= '0;
      rx_tone_word <= '0;
      audio_word   <= '0;
      selcall_word <= '0;
    end else if (wr_en) begin
      case (wr_cmd)
        CMD_SIGCTRL: sig_ctrl  <= wr_data[BYTE_W-1:0];
        CMD_SETUP:   sig_setup <= wr_data[BYTE_W-1:0];
        CMD_DCS_HI:  dcs_code[3*BYTE_W-1:2*BYTE_W] <= wr_data[BYTE_W-1:0];
        CMD_DCS_MID: dcs_code[2*BYTE_W-1:BYTE_W]   <= wr_data[BYTE_W-1:0];
        CMD_DCS_LO:  dcs_code[BYTE_W-1:0]          <= wr_data[BYTE_W-1:0];
        CMD_GENCTRL: gen_ctrl  <= wr_data[BYTE_W-1:0];
        CMD_TIMER:   gp_timer  <= wr_data[BYTE_W-1:0];
        CMD_MASK:    irq_mask  <= wr_data[BYTE_W-1:0];
        CMD_SUBTONE: subtone_word <= wr_data;
        CMD_RXTONE:  rx_tone_word <= wr_data;
        CMD_AUDIO:   audio_word   <= wr_data;
        CMD_SELCALL: selcall_word <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) irq_flags <= '0;
    else irq_flags <= (rd_load ? '0 : irq_flags) | flag_set;
  end

  assign irq_pull = |(irq_flags & irq_mask);

  // R9: flag bits only fall on a read or a reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_load && !soft_rst) |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));
  // R4: reset command leaves registers and flags clear
  a_r4_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (irq_flags == '0 && sig_ctrl == '0 && irq_mask == '0 &&
                  dcs_code == '0 && selcall_word == '0));
  // R10: no request while nothing is enabled
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq_pull);
endmodule

// File: rtl/sigctl_serial_port.sv
module sigctl_serial_port
  import sp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        csn,
  input  logic [7:0]  flag_set,
  output logic        reply_data,
  output logic        reply_oe,
  output logic        irq_pull,
  output logic [7:0]  sig_ctrl,
  output logic [7:0]  sig_setup,
  output logic [23:0] dcs_code,
  output logic [7:0]  gen_ctrl,
  output logic [7:0]  gp_timer,
  output logic [7:0]  irq_mask,
  output logic [15:0] subtone_word,
  output logic [15:0] rx_tone_word,
  output logic [15:0] audio_word,
  output logic [15:0] selcall_word,
  output logic [7:0]  irq_flags
);
  logic              byte_vld, xfer_idle, wr_en, soft_rst, rd_load;
  logic [BYTE_W-1:0] byte_val, wr_cmd;
  logic [WORD_W-1:0] wr_data;

  sp_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .csn(csn),
    .rd_load(rd_load), .rd_value(irq_flags),
    .byte_vld(byte_vld), .byte_val(byte_val), .xfer_idle(xfer_idle),
    .reply_data(reply_data), .reply_oe(reply_oe)
  );

  sp_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_val(byte_val),
    .xfer_idle(xfer_idle), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .soft_rst(soft_rst), .rd_load(rd_load)
  );

  sp_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .soft_rst(soft_rst), .rd_load(rd_load), .flag_set(flag_set),
    .sig_ctrl(sig_ctrl), .sig_setup(sig_setup), .dcs_code(dcs_code),
    .gen_ctrl(gen_ctrl), .gp_timer(gp_timer), .irq_mask(irq_mask),
    .subtone_word(subtone_word), .rx_tone_word(rx_tone_word),
    .audio_word(audio_word), .selcall_word(selcall_word),
    .irq_flags(irq_flags), .irq_pull(irq_pull)
  );
endmodule

// File: tb/tb_sigctl_serial_port.sv
module tb_sigctl_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, csn = 1;
  logic [7:0] flag_set = '0;
  logic reply_data, reply_oe, irq_pull;
  logic [7:0] sig_ctrl, sig_setup, gen_ctrl, gp_timer, irq_mask, irq_flags;
  logic [23:0] dcs_code;
  logic [15:0] subtone_word, rx_tone_word, audio_word, selcall_word;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sigctl_serial_port dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .csn(csn), .flag_set(flag_set),
    .reply_data(reply_data), .reply_oe(reply_oe), .irq_pull(irq_pull),
    .sig_ctrl(sig_ctrl), .sig_setup(sig_setup), .dcs_code(dcs_code),
    .gen_ctrl(gen_ctrl), .gp_timer(gp_timer), .irq_mask(irq_mask),
    .subtone_word(subtone_word), .rx_tone_word(rx_tone_word),
    .audio_word(audio_word), .selcall_word(selcall_word), .irq_flags(irq_flags)
  );

  function automatic logic [127:0] snap();
    return {sig_ctrl, sig_setup, dcs_code, gen_ctrl, gp_timer, irq_mask,
            subtone_word, rx_tone_word, audio_word, selcall_word};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; idle(HALF); sclk = 1; idle(HALF); sclk = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic sel();   csn = 0; idle(HALF); endtask
  task automatic desel(); idle(HALF); csn = 1; idle(10); endtask

  task automatic wr1(input logic [7:0] c, input logic [7:0] d);
    sel(); send_byte(c); send_byte(d); desel();
  endtask

  task automatic wr2(input logic [7:0] c, input logic [15:0] d);
    sel(); send_byte(c); send_byte(d[15:8]); send_byte(d[7:0]); desel();
  endtask

  task automatic rd_flags(input logic [7:0] expv);
    exp_q.push_back(expv);
    sel(); send_byte(8'h8F); send_byte(8'h00); desel();
  endtask

  task automatic pulse(input logic [7:0] f);
    @(negedge clk); flag_set = f; @(negedge clk); flag_set = '0; idle(2);
  endtask

  // Scoreboard monitor: collects reply bits at host sampling edges (R7)
  initial begin
    logic [7:0] rb = '0;
    int rc = 0;
    forever begin
      @(posedge sclk);
      if (reply_oe) begin
        rb = {rb[6:0], reply_data};
        rc++;
        if (rc == 8) begin
          rc = 0;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R7 actual=%0h expected=none (unexpected reply)", rb);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (rb !== e) begin
              errors++;
              $display("FAIL R7 actual=%0h expected=%0h", rb, e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] s;
    idle(5); rst_n = 1; idle(5);
    // R1 reset state
    chk("R1", snap(), '0);
    chk("R1", {irq_flags, reply_oe, irq_pull}, '0);

    // R2 single-byte registers
    wr1(8'h80, 8'hA5); chk("R2", sig_ctrl, 8'hA5);
    wr1(8'h82, 8'h3C); chk("R2", sig_setup, 8'h3C);
    wr1(8'h85, 8'h12); wr1(8'h86, 8'h34); wr1(8'h87, 8'h56);
    chk("R2", dcs_code, 24'h123456);
    wr1(8'h88, 8'h81); chk("R2", gen_ctrl, 8'h81);
    wr1(8'h8B, 8'h7E); chk("R2", gp_timer, 8'h7E);

    // R3 two-byte registers, high byte first
    wr2(8'h83, 16'h1F2E); chk("R3", subtone_word, 16'h1F2E);
    wr2(8'h84, 16'hB00C); chk("R3", rx_tone_word, 16'hB00C);
    wr2(8'h8A, 16'h2211); chk("R3", audio_word, 16'h2211);
    wr2(8'h8D, 16'h0F0F); chk("R3", selcall_word, 16'h0F0F);

    // R11 trailing bytes in the same window
    sel(); send_byte(8'h80); send_byte(8'h5A); send_byte(8'hC3); send_byte(8'h99); desel();
    chk("R11", sig_ctrl, 8'h5A);

    // R5 abort mid-byte, then abort between data bytes
    sel(); send_byte(8'h88); send_bit(0); send_bit(1); send_bit(1); desel();
    chk("R5", gen_ctrl, 8'h81);
    sel(); send_byte(8'h8D); send_byte(8'hFF); desel();
    chk("R5", selcall_word, 16'h0F0F);
    wr1(8'h8B, 8'h77); chk("R5", gp_timer, 8'h77);

    // R6 unknown commands with data
    s = snap();
    sel(); send_byte(8'h90); send_byte(8'hEE); send_byte(8'hEE); desel();
    sel(); send_byte(8'h00); send_byte(8'h11); desel();
    sel(); send_byte(8'h81); send_byte(8'h22); send_byte(8'h33); desel();
    chk("R6", snap(), s);

    // R9 / R10 flags and mask
    wr1(8'h8E, 8'h02); chk("R2", irq_mask, 8'h02);
    pulse(8'h05); chk("R9", irq_flags, 8'h05);
    chk("R10", irq_pull, 1'b0);
    pulse(8'h00); chk("R9", irq_flags, 8'h05);
    wr1(8'h8E, 8'h04); chk("R10", irq_pull, 1'b1);

    // R7 / R8 read and clear
    rd_flags(8'h05);
    chk("R8", irq_flags, 8'h00);
    chk("R10", irq_pull, 1'b0);
    chk("R7", reply_oe, 1'b0);
    pulse(8'h80); chk("R8", irq_flags, 8'h80);
    rd_flags(8'h80);
    pulse(8'h21); pulse(8'h80);
    rd_flags(8'hA1);
    chk("R8", irq_flags, 8'h00);

    // R4 data-less reset command
    pulse(8'h44);
    sel(); send_byte(8'h01); desel();
    chk("R4", snap(), '0);
    chk("R4", irq_flags, 8'h00);
    wr1(8'h80, 8'h3D); chk("R4", sig_ctrl, 8'h3D);

    idle(20);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 actual=%0d expected=0 replies outstanding", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule